// File: doc/BRIEF.md
# Byte Register, Flag and Stack Datapath

This block is the data side of a small 8-bit processor. Four byte-wide general registers sit on one internal bus, together with a four-flag status register and a stack pointer that counts downward. Each cycle, a controller presents one operation code together with a destination select, a source select and an immediate byte. The block then moves data between registers, adds or subtracts, pushes a register onto the stack, pops a byte into a register, or sets or clears the interrupt-enable flag.

Stack traffic goes to an external 256-byte memory through three paths: an 8-bit address, a write-data byte and a read-data byte. Two control lines go with them. One marks a memory access, and the other marks that access as a write. The memory returns read data one cycle after the address is presented. Because of this, a pop takes two cycles, and `ready` is low during the second one. The register contents, the flags and the stack pointer are brought out so that the surrounding logic can observe them.

Top module: `byte_datapath`

## Requirements
- R1: After reset all four registers are 0x00, the stack pointer is 0xBF, all flags are 0, `ready` is 1 and `stack_fault` is 0.
- R2: When `ready` is 1, `op`=1 copies register `src` into register `dst`, and `op`=2 loads `imm` into register `dst`. The result is visible on `regs_out` (register i at bits 8i+7..8i) after the next clock edge.
- R3: `op`=3 writes `dst + src` modulo 256 into `dst`. The flags are packed in `flags_out` as bit0 zero, bit1 sign, bit2 overflow, bit3 interrupt-enable. This operation sets zero when the result is 0, sets sign to result bit 7, and sets overflow when both operands share a sign that differs from the result's sign. The carry out is not stored.
- R4: `op`=4 writes `dst - src` modulo 256 into `dst` and updates zero and sign as in R3. Overflow is set when the two operands have different signs and the result's sign differs from that of `dst`.
- R5: Register moves, pushes and pops leave the zero, sign and overflow flags unchanged.
- R6: `op`=5 (push) drives `ctl_mem`=1, `ctl_wr`=1, `bus_addr`=stack pointer and `bus_dout`=register `src` in the same cycle. After the edge, the stack pointer is one lower.
- R7: `op`=6 (pop) first drives `ctl_mem`=1, `ctl_wr`=0 and `bus_addr`=stack pointer+1, and the stack pointer becomes that value. In the next cycle `ready` is 0 and the byte on `bus_din` is written into `dst`.
- R8: A push with the stack pointer at 0x00, or a pop with it at 0xBF, makes no memory access and leaves the stack pointer and registers unchanged. It raises `stack_fault` for the one cycle after the edge.
- R9: `op`=7 sets the interrupt-enable flag and `op`=8 clears it. Neither touches the other flags.
- R10: `ctl_mem` and `ctl_wr` are 0 whenever no push or pop is being issued. A memory access and a register write never happen in the same cycle.
- R11: An operation presented while `ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code (0 none, 1..8 as in the requirements) |
| dst | input | 2 | Destination register select |
| src | input | 2 | Source register select |
| imm | input | 8 | Immediate byte for load |
| ready | output | 1 | High when a new operation is accepted |
| bus_addr | output | 8 | Memory address |
| bus_dout | output | 8 | Write data to memory |
| bus_din | input | 8 | Read data from memory, one cycle after the address |
| ctl_mem | output | 1 | Memory access in this cycle |
| ctl_wr | output | 1 | Access is a write (0 = read) |
| regs_out | output | 32 | The four registers, register 0 in the low byte |
| flags_out | output | 4 | Zero, sign, overflow, interrupt-enable (bit0..bit3) |
| sp_out | output | 8 | Stack pointer |
| stack_fault | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
Arithmetic is tried with operand pairs chosen to separate the flag rules. Adding 0x7F and 0x01 overflows into a negative result. Adding 0xFF and 0x01 wraps to zero, which has a carry but no overflow. Subtracting 0x01 from 0x80 overflows the other way. A register minus itself gives zero. Data is pushed with distinct values and popped back to confirm last-in first-out ordering, and a load is presented during the pop's wait cycle to show it is dropped. The stack is then driven from empty to full, so that both refusal boundaries are reached and the stack pointer is compared against a behavioural model on every clock.

// File: rtl/byte_datapath.sv
module byte_datapath #(
  parameter int W = 8,
  parameter int NREG = 4,
  parameter logic [7:0] SP_INIT = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic [$clog2(NREG)-1:0] src,
  input  logic [W-1:0]      imm,
  output logic              ready,
  output logic [W-1:0]      bus_addr,
  output logic [W-1:0]      bus_dout,
  input  logic [W-1:0]      bus_din,
  output logic              ctl_mem,
  output logic              ctl_wr,
  output logic [NREG*W-1:0] regs_out,
  output logic [3:0]        flags_out,
  output logic [W-1:0]      sp_out,
  output logic              stack_fault
);
  localparam int SW = $clog2(NREG);
  localparam logic [3:0] OP_MOVR = 4'd1, OP_MOVI = 4'd2, OP_ADD = 4'd3, OP_SUB = 4'd4,
                         OP_PUSH = 4'd5, OP_POP = 4'd6, OP_SETI = 4'd7, OP_CLRI = 4'd8;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] SP_TOP = W'(SP_INIT);

  logic [W-1:0] rf [NREG];
  logic [W-1:0] sp;
  logic fz, fs, fo, fi;
  logic pend;
  logic [SW-1:0] pend_dst;
  logic fault_q;

  logic [W-1:0] a, b, bx, result, ibus;
  logic [W:0] full;
  logic ovf, is_sub, is_arith, go, wr_en;
  logic push_ok, push_bad, pop_ok, pop_bad;
  logic [SW-1:0] wr_idx;

  assign ready = !pend;
  assign go = !pend;
  assign a = rf[dst];
  assign b = rf[src];
  assign is_sub = (op == OP_SUB);
  assign is_arith = go && (op == OP_ADD || is_sub);
  assign bx = is_sub ? ~b : b;
  assign full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, is_sub};
  assign result = full[W-1:0];
  assign ovf = (a[W-1] == bx[W-1]) && (result[W-1] != a[W-1]);

  assign push_ok  = go && op == OP_PUSH && sp != ZERO;
  assign push_bad = go && op == OP_PUSH && sp == ZERO;
  assign pop_ok   = go && op == OP_POP && sp != SP_TOP;
  assign pop_bad  = go && op == OP_POP && sp == SP_TOP;

  assign ctl_mem  = push_ok || pop_ok;
  assign ctl_wr   = push_ok;
  assign bus_addr = pop_ok ? sp + ONE : sp;
  assign bus_dout = b;

  always_comb begin
    ibus = '0;
    wr_en = 1'b0;
    wr_idx = dst;
    if (pend) begin
      ibus = bus_din;
      wr_en = 1'b1;
      wr_idx = pend_dst;
    end else begin
      case (op)
        OP_MOVR: begin ibus = b; wr_en = 1'b1; end
        OP_MOVI: begin ibus = imm; wr_en = 1'b1; end
        OP_ADD, OP_SUB: begin ibus = result; wr_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wr_idx] <= ibus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= SP_TOP;
      {fz, fs, fo, fi} <= '0;
      pend <= 1'b0;
      pend_dst <= '0;
      fault_q <= 1'b0;
    end else begin
      pend <= pop_ok;
      if (pop_ok) pend_dst <= dst;
      fault_q <= push_bad || pop_bad;
      if (push_ok) sp <= sp - ONE;
      else if (pop_ok) sp <= sp + ONE;
      if (is_arith) begin
        fz <= (result == ZERO);
        fs <= result[W-1];
        fo <= ovf;
      end
      if (go && op == OP_SETI) fi <= 1'b1;
      else if (go && op == OP_CLRI) fi <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign regs_out[g*W +: W] = rf[g];
  end

  assign flags_out = {fi, fo, fs, fz};
  assign sp_out = sp;
  assign stack_fault = fault_q;
endmodule

// File: rtl/byte_datapath_chk.sv
module byte_datapath_chk #(
  parameter int W = 8,
  parameter logic [7:0] SP_INIT = 8'hBF
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic         ready,
  input logic         ctl_mem,
  input logic         ctl_wr,
  input logic [3:0]   flags_out,
  input logic [W-1:0] sp_out,
  input logic         stack_fault,
  input logic         wr_en
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] SP_TOP = W'(SP_INIT);

  p_push_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op == 4'd5 && sp_out != '0) |=> sp_out == $past(sp_out) - ONE);

  p_pop_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op == 4'd6 && sp_out != SP_TOP) |=> (!ready && sp_out == $past(sp_out) + ONE));

  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op == 4'd5 && sp_out == '0) |=> (stack_fault && $stable(sp_out)));

  p_empty_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op == 4'd6 && sp_out == SP_TOP) |-> !ctl_mem);

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (op == 4'd1 || op == 4'd2 || op == 4'd5 || op == 4'd6)) |=> $stable(flags_out[2:0]));

  p_int_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op == 4'd7) |=> (flags_out[3] && $stable(flags_out[2:0])));

  p_wr_needs_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> ctl_mem);

  p_no_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_mem && wr_en));

  p_busy_no_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ctl_mem);
endmodule

bind byte_datapath byte_datapath_chk #(.W(W), .SP_INIT(SP_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .ready(ready), .ctl_mem(ctl_mem), .ctl_wr(ctl_wr),
  .flags_out(flags_out), .sp_out(sp_out), .stack_fault(stack_fault), .wr_en(wr_en)
);

// File: tb/sim_byte_datapath.sv
`timescale 1ns/1ps
module sim_byte_datapath;
  logic clk = 0, rst_n = 0;
  logic [3:0] op = 0;
  logic [1:0] dst = 0, src = 0;
  logic [7:0] imm = 0;
  logic ready, ctl_mem, ctl_wr, stack_fault;
  logic [7:0] bus_addr, bus_dout, bus_din, sp_out;
  logic [31:0] regs_out;
  logic [3:0] flags_out;

  always #4 clk = ~clk;

  byte_datapath u0 (.clk(clk), .rst_n(rst_n), .op(op), .dst(dst), .src(src), .imm(imm),
    .ready(ready), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .ctl_mem(ctl_mem), .ctl_wr(ctl_wr), .regs_out(regs_out), .flags_out(flags_out),
    .sp_out(sp_out), .stack_fault(stack_fault));

  logic [7:0] ram [256];
  logic [7:0] rdq = 0;
  always @(posedge clk) begin
    if (ctl_mem && ctl_wr) ram[bus_addr] <= bus_dout;
    rdq <= ram[bus_addr];
  end
  assign bus_din = rdq;

  int checks = 0, fails = 0;
  int mr[4];
  int msp;
  int mmem[256];
  bit mz, ms, mo, mi, mfault;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag, bit exp_ready);
    for (int i = 0; i < 4; i++) check({tag, " reg"}, regs_out[i*8 +: 8], mr[i]);
    check({tag, " sp"}, sp_out, msp);
    check({tag, " flags"}, flags_out, {mi, mo, ms, mz});
    check({tag, " fault"}, stack_fault, mfault);
    check({tag, " ready"}, ready, exp_ready);
  endtask

  task automatic step(string tag, int o, int d, int s, int im);
    int a, b, r;
    bit popping;
    op = 4'(o); dst = 2'(d); src = 2'(s); imm = 8'(im);
    a = mr[d]; b = mr[s];
    popping = 0;
    mfault = 0;
    #1;
    case (o)
      1: mr[d] = b;
      2: mr[d] = im & 255;
      3: begin
        r = (a + b) & 255; mr[d] = r;
        mz = (r == 0); ms = r[7]; mo = (a[7] == b[7]) && (r[7] != a[7]);
      end
      4: begin
        r = (a - b) & 255; mr[d] = r;
        mz = (r == 0); ms = r[7]; mo = (a[7] != b[7]) && (r[7] != a[7]);
      end
      5: if (msp == 0) begin
        check({tag, " R8 no access"}, ctl_mem, 0);
        mfault = 1;
      end else begin
        check({tag, " R6 ctl"}, {ctl_mem, ctl_wr}, 3);
        check({tag, " R6 addr"}, bus_addr, msp);
        check({tag, " R6 data"}, bus_dout, b);
        mmem[msp] = b; msp--;
      end
      6: if (msp == 'hBF) begin
        check({tag, " R8 no access"}, ctl_mem, 0);
        mfault = 1;
      end else begin
        check({tag, " R7 ctl"}, {ctl_mem, ctl_wr}, 2);
        check({tag, " R7 addr"}, bus_addr, msp + 1);
        msp++; popping = 1;
      end
      7: mi = 1;
      8: mi = 0;
      default: ;
    endcase
    if (o != 5 && o != 6) check({tag, " R10 idle ctl"}, {ctl_mem, ctl_wr}, 0);
    @(negedge clk);
    if (popping) begin
      compare({tag, " R7 wait"}, 0);
      op = 4'd2; dst = 2'(d); imm = 8'h5A;
      mr[d] = mmem[msp];
      @(negedge clk);
      compare({tag, " R7/R11 pop data"}, 1);
    end else begin
      compare(tag, 1);
    end
    op = 0;
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 0; mmem[i] = 0; end
    for (int i = 0; i < 4; i++) mr[i] = 0;
    msp = 'hBF; {mz, ms, mo, mi, mfault} = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset", 1);
    step("R2 movi", 2, 0, 0, 'h7F);
    step("R2 movi", 2, 1, 0, 'h01);
    step("R2 movi", 2, 2, 0, 'h80);
    step("R2 movi", 2, 3, 0, 'hFF);
    step("R3 add ovf", 3, 0, 1, 0);
    step("R2 R5 movr", 1, 0, 3, 0);
    step("R3 add wrap zero", 3, 0, 1, 0);
    step("R4 sub ovf", 4, 2, 1, 0);
    step("R4 sub zero", 4, 3, 3, 0);
    step("R9 seti", 7, 0, 0, 0);
    step("R9 clri", 8, 0, 0, 0);
    step("R9 seti", 7, 0, 0, 0);
    step("R2 movi", 2, 3, 0, 'hC3);
    step("R8 pop empty", 6, 0, 0, 0);
    step("R6 push", 5, 0, 3, 0);
    step("R6 R5 push", 5, 0, 2, 0);
    step("R7 pop", 6, 1, 0, 0);
    step("R7 pop", 6, 0, 0, 0);
    step("R8 pop empty", 6, 0, 0, 0);
    for (int k = 0; k < 191; k++) begin
      step("R2 fill load", 2, 1, 0, k ^ 'h35);
      step("R6 fill push", 5, 0, 1, 0);
    end
    step("R8 push full", 5, 0, 2, 0);
    step("R8 push full again", 5, 0, 2, 0);
    step("R3 add after fault", 3, 2, 2, 0);
    for (int k = 0; k < 4; k++) step("R7 drain pop", 6, k, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule